// File: doc/BRIEF.md
# Multi-Mode Host Write Port

This block is the write-only host port of a small display controller. A host sends bytes to it over one of three paths: a three-wire serial link (chip select, serial clock, serial data), an 8-bit parallel bus, or a 4-bit parallel bus that carries each byte as two nibbles. On the parallel paths the strobe follows either the 80-style convention (active-low write strobe, data taken on its rising edge) or the 68-style convention (active-high enable, data taken on its falling edge).

Three static mode pins choose the path: parallel versus serial, bus width, and strobe style. All host inputs are asynchronous to the system clock. Two flip-flops synchronise them, and edges are found in the system clock domain. Each finished transfer produces a single-cycle pulse carrying the byte and its data/command flag. The display logic behind the port treats the byte as display data when the flag is high and as a command when it is low.

Top module: `host_write_port`

## Requirements
- R1: While reset is active and in the first cycle after it, `out_valid` is low and `out_data` and `out_a0` are zero.
- R2: In serial mode (`par_sel` low), `d[7]` is serial data and `d[6]` is the serial clock. Bits are taken MSB first on rising serial clock edges. The eighth rising edge completes the byte, and `out_a0` equals the `a0` level present at that eighth edge.
- R3: In serial mode, deasserting chip select (`cs_n` high) discards a partly shifted byte and clears the bit count. The next selected transfer starts again at bit 7.
- R4: In 80 style (`enable_style` low), the parallel bus is captured on the rising edge of the active-low `strobe`. Its falling edge captures nothing.
- R5: In 68 style (`enable_style` high), the parallel bus is captured on the falling edge of the active-high `strobe`. Its rising edge captures nothing.
- R6: With the 4-bit bus (`wide_bus` low), a byte takes two strobes on `d[7:4]`: the upper nibble first, then the lower nibble. `d[3:0]` is ignored. No output is produced after the first strobe. `out_a0` comes from the second strobe.
- R7: In 4-bit mode, deasserting chip select returns the nibble phase to upper-nibble-expected, so a lone upper nibble is discarded.
- R8: While `cs_n` is high, strobe, serial clock, data and `a0` activity produce no output.
- R9: `out_a0` high marks display data and `out_a0` low marks a command, on every path.
- R10: Every transfer yields exactly one `out_valid` pulse, one cycle long. It appears three clock cycles after the capturing host edge is applied.
- R11: Reset acts whether or not chip select is asserted. A serial transfer that reset interrupts leaves no residue in the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_sel | input | 1 | Static mode pin: 1 parallel, 0 serial |
| wide_bus | input | 1 | Static mode pin: 1 8-bit bus, 0 4-bit bus on d[7:4] |
| enable_style | input | 1 | Static mode pin: 1 68 style, 0 80 style |
| cs_n | input | 1 | Active-low chip select |
| a0 | input | 1 | Data/command flag: 1 data, 0 command |
| strobe | input | 1 | Write strobe (80 style) or enable (68 style) |
| d | input | 8 | Parallel data; in serial mode d[7] is data and d[6] is clock |
| out_valid | output | 1 | One-cycle pulse per completed byte |
| out_data | output | 8 | Completed byte |
| out_a0 | output | 1 | Data/command flag of the completed byte |

## Verification
A bit counter or nibble phase that is out of step with the host shows at the ports as a byte with shifted or swapped bits. It can also show as a pulse after the wrong number of edges, or as a missing pulse. The bench finds this within one transfer, because it checks every byte and the pulse count after every strobe. Deselect and reset cases are placed straight after partial transfers, so a stale count shows in the very next byte. A wrong edge choice or a wrong synchroniser depth shows as a pulse on the leading strobe edge, or as a latency other than three cycles.

// File: rtl/host_write_port.sv
module host_write_port #(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_sel,
  input  logic              wide_bus,
  input  logic              enable_style,
  input  logic              cs_n,
  input  logic              a0,
  input  logic              strobe,
  input  logic [BYTE_W-1:0] d,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_a0
);

  localparam int NIB_W = BYTE_W / 2;
  localparam int CNT_W = $clog2(BYTE_W);
  localparam int PIPE_W = BYTE_W + 3;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  // {cs_n, a0, strobe, d}; strobe resets to its idle level
  logic [SYNC_STAGES-1:0][PIPE_W-1:0] pipe;
  logic [PIPE_W-1:0] idle_word;
  assign idle_word = {1'b1, 1'b0, ~enable_style, {BYTE_W{1'b0}}};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pipe <= {SYNC_STAGES{idle_word}};
    else        pipe <= {pipe[SYNC_STAGES-2:0], {cs_n, a0, strobe, d}};

  logic              cs_s, a0_s, stb_s, scl_s, si_s;
  logic [BYTE_W-1:0] d_s;
  assign {cs_s, a0_s, stb_s, d_s} = pipe[SYNC_STAGES-1];
  assign scl_s = d_s[BYTE_W-2];
  assign si_s  = d_s[BYTE_W-1];

  logic stb_d, scl_d;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stb_d <= ~enable_style;
      scl_d <= 1'b0;
    end else begin
      stb_d <= stb_s;
      scl_d <= scl_s;
    end

  logic par_evt, ser_evt;
  assign par_evt = par_sel & ~cs_s & (enable_style ? (~stb_s & stb_d) : (stb_s & ~stb_d));
  assign ser_evt = ~par_sel & ~cs_s & scl_s & ~scl_d;

  logic [BYTE_W-2:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (cs_s || par_sel) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (ser_evt) begin
      shreg   <= {shreg[BYTE_W-3:0], si_s};
      bit_cnt <= bit_cnt + 1'b1;
    end

  logic             phase;
  logic [NIB_W-1:0] hi_nib;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase  <= 1'b0;
      hi_nib <= '0;
    end else if (cs_s || !par_sel || wide_bus) begin
      phase  <= 1'b0;
    end else if (par_evt) begin
      phase <= ~phase;
      if (!phase) hi_nib <= d_s[BYTE_W-1 -: NIB_W];
    end

  logic ser_done, par_done;
  assign ser_done = ser_evt & (bit_cnt == LAST_BIT);
  assign par_done = par_evt & (wide_bus | phase);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_a0    <= 1'b0;
    end else begin
      out_valid <= ser_done | par_done;
      if (ser_done | par_done) begin
        out_a0   <= a0_s;
        out_data <= ser_done ? {shreg, si_s}
                  : wide_bus ? d_s
                  : {hi_nib, d_s[BYTE_W-1 -: NIB_W]};
      end
    end

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  a_r8_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !out_valid);

  a_r3_deselect_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (bit_cnt == '0) && !phase);

  a_r2_eighth_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !par_sel) |-> (bit_cnt == '0) && ($past(bit_cnt) == LAST_BIT));

  a_r6_nibble_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && par_sel && !wide_bus) |-> !phase && $past(phase));

endmodule

// File: tb/tb_host_write_port.sv
module tb_host_write_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic par_sel = 1'b1, wide_bus = 1'b1, enable_style = 1'b0;
  logic cs_n = 1'b1, a0 = 1'b0, strobe = 1'b1;
  logic [7:0] d = 8'h00;
  logic out_valid, out_a0;
  logic [7:0] out_data;

  always #4 clk = ~clk;

  host_write_port dut (.clk, .rst_n, .par_sel, .wide_bus, .enable_style,
    .cs_n, .a0, .strobe, .d, .out_valid, .out_data, .out_a0);

  int checks = 0, failures = 0;
  int pulses = 0, long_pulses = 0, cyc = 0, pulse_cyc = 0;
  logic [7:0] cap_data = 8'h00;
  logic cap_a0 = 1'b0, prev_valid = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (out_valid) begin
      pulses++;
      cap_data = out_data;
      cap_a0 = out_a0;
      pulse_cyc = cyc;
      if (prev_valid) long_pulses++;
    end
    prev_valid = out_valid;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_byte(input int p0, input logic [7:0] v, input logic a, input string tag);
    chk(pulses == p0 + 1, {tag, " pulse count"}, pulses - p0, 1);
    chk(cap_data == v, {tag, " data"}, cap_data, v);
    chk(cap_a0 == a, {tag, " a0"}, cap_a0, a);
  endtask

  task automatic set_style(input logic sty);
    cs_n = 1'b1; enable_style = sty; strobe = ~sty; idle(5);
  endtask

  task automatic strobe_once(input logic [7:0] v, input logic a, output int lead_new, output int edge_cyc);
    int p;
    a0 = a; d = v; idle(4);
    p = pulses;
    strobe = enable_style; idle(5);
    lead_new = pulses - p;
    @(negedge clk);
    strobe = ~enable_style; edge_cyc = cyc;
    idle(5);
  endtask

  task automatic ser_bits(input logic [7:0] v, input int n, input logic a);
    d = 8'h00; a0 = ~a; idle(3);
    for (int i = 0; i < n; i++) begin
      d[7] = v[7-i];
      if (i == n - 1) a0 = a;
      idle(3);
      d[6] = 1'b1; idle(3);
      d[6] = 1'b0;
    end
    idle(2);
    a0 = ~a; idle(4);
  endtask

  localparam int NV = 8;
  localparam logic [9:0] VEC [NV] = '{
    {1'b0, 1'b1, 8'hA5}, {1'b0, 1'b0, 8'h3C}, {1'b1, 1'b1, 8'hFF}, {1'b1, 1'b0, 8'h00},
    {1'b0, 1'b1, 8'h81}, {1'b1, 1'b1, 8'h7E}, {1'b0, 1'b0, 8'h01}, {1'b1, 1'b0, 8'hC3}};

  initial begin
    #1600000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int p, lead, ecyc;
    idle(3);
    // R1 reset state
    chk(out_valid == 1'b0 && out_data == 8'h00 && out_a0 == 1'b0, "R1 outputs in reset",
        {out_valid, out_data, out_a0}, 0);
    rst_n = 1'b1; idle(1);
    chk(out_valid == 1'b0 && out_data == 8'h00, "R1 after reset", {out_valid, out_data}, 0);
    idle(4);

    // R4 R5 R9 R10 vector walk, 8-bit parallel
    for (int k = 0; k < NV; k++) begin
      set_style(VEC[k][9]);
      cs_n = 1'b0;
      p = pulses;
      strobe_once(VEC[k][7:0], VEC[k][8], lead, ecyc);
      chk(lead == 0, VEC[k][9] ? "R5 leading enable edge" : "R4 leading strobe edge", lead, 0);
      chk_byte(p, VEC[k][7:0], VEC[k][8], VEC[k][9] ? "R5 R9 68 style" : "R4 R9 80 style");
      chk(pulse_cyc - ecyc == 3, "R10 latency", pulse_cyc - ecyc, 3);
      cs_n = 1'b1; idle(3);
    end
    chk(long_pulses == 0, "R10 pulse width", long_pulses, 0);

    // R8 parallel activity while deselected
    set_style(1'b0);
    p = pulses;
    strobe_once(8'h5A, 1'b1, lead, ecyc);
    strobe_once(8'hA5, 1'b0, lead, ecyc);
    chk(pulses == p, "R8 parallel deselected", pulses - p, 0);

    // R6 4-bit bus, 80 style
    wide_bus = 1'b0; cs_n = 1'b0; idle(4);
    p = pulses;
    strobe_once(8'hBF, 1'b0, lead, ecyc);
    chk(pulses == p, "R6 no output after upper nibble", pulses - p, 0);
    strobe_once(8'h40, 1'b1, lead, ecyc);
    chk_byte(p, 8'hB4, 1'b1, "R6 nibble pair");
    // R6 68 style 4-bit
    set_style(1'b1); cs_n = 1'b0; idle(4);
    p = pulses;
    strobe_once(8'h2A, 1'b1, lead, ecyc);
    strobe_once(8'hD5, 1'b0, lead, ecyc);
    chk_byte(p, 8'h2D, 1'b0, "R6 R9 nibble pair 68 style");
    // R7 lone upper nibble dropped by deselect
    p = pulses;
    strobe_once(8'hE0, 1'b1, lead, ecyc);
    cs_n = 1'b1; idle(5); cs_n = 1'b0; idle(4);
    strobe_once(8'h90, 1'b1, lead, ecyc);
    chk(pulses == p, "R7 phase restarted", pulses - p, 0);
    strobe_once(8'h60, 1'b1, lead, ecyc);
    chk_byte(p, 8'h96, 1'b1, "R7 fresh pair");
    cs_n = 1'b1; wide_bus = 1'b1; idle(4);

    // R2 serial
    par_sel = 1'b0; strobe = 1'b0; idle(4);
    cs_n = 1'b0; p = pulses;
    ser_bits(8'hC6, 8, 1'b1);
    chk_byte(p, 8'hC6, 1'b1, "R2 R9 serial data");
    p = pulses;
    ser_bits(8'h1B, 8, 1'b0);
    chk_byte(p, 8'h1B, 1'b0, "R2 R9 serial command");
    // R3 partial byte discarded
    p = pulses;
    ser_bits(8'hFF, 5, 1'b1);
    cs_n = 1'b1; idle(5); cs_n = 1'b0; idle(3);
    chk(pulses == p, "R3 partial no output", pulses - p, 0);
    ser_bits(8'h35, 8, 1'b1);
    chk_byte(p, 8'h35, 1'b1, "R3 restart at bit 7");
    // R8 serial clocks while deselected
    cs_n = 1'b1; idle(4);
    p = pulses;
    ser_bits(8'hAA, 8, 1'b1);
    ser_bits(8'h55, 8, 1'b1);
    chk(pulses == p, "R8 serial deselected", pulses - p, 0);
    // R11 reset with chip select asserted
    cs_n = 1'b0; idle(4);
    ser_bits(8'hFF, 3, 1'b0);
    rst_n = 1'b0; idle(2);
    chk(out_valid == 1'b0 && out_data == 8'h00, "R11 reset while selected", {out_valid, out_data}, 0);
    rst_n = 1'b1; idle(5);
    p = pulses;
    ser_bits(8'h6D, 8, 1'b0);
    chk_byte(p, 8'h6D, 1'b0, "R11 clean byte after reset");
    chk(long_pulses == 0, "R10 pulse width final", long_pulses, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule